// File: doc/BRIEF.md
# Segmented Address Translator With Privilege Check

This block turns a virtual address, made of a 16-bit segment selector and a 32-bit offset, into a 32-bit linear address. It holds two small descriptor tables. One is global and shared. The other is local to the running process. Each descriptor gives a segment base, an inclusive limit, a descriptor privilege level and a present bit.

A request strobe starts a translation. The block picks a descriptor from the selector and checks the index range, the present bit, the privilege and the limit. If every check passes, it adds the base to the offset. The result, or a fault with a cause code, appears on the registered outputs one cycle later. Privilege levels run from 0 (most trusted) to 3 (least trusted).

A write port loads descriptors into either table. When translation is switched off, the offset goes straight through as the linear address and no check is applied.

Top module: `seg_xlat`

## Requirements
- R1: While reset is high, and in the cycle after it, `valid`, `fault`, `cause` and `lin_addr` are all zero. Reset also marks every descriptor in both tables as not present.
- R2: A request sampled at a clock edge produces `valid`=1 for exactly the next cycle. With no request, `valid` and `fault` are 0 and `lin_addr` and `cause` are 0.
- R3: Selector bits [1:0] hold the requested privilege. Bit 2 chooses the table (0 global, 1 local). Bits [15:3] hold the descriptor index.
- R4: When no fault occurs, `lin_addr` equals base plus offset, wrapping modulo 2^32.
- R5: The limit is inclusive. An offset greater than the limit faults with cause 2. An offset equal to the limit translates.
- R6: A descriptor whose present bit is clear faults with cause 1.
- R7: If the larger number of the current privilege and the requested privilege is greater than the descriptor privilege, the access faults with cause 3.
- R8: An index at or above the parameter ENTRIES faults with cause 4.
- R9: When several faults apply, only one cause is reported, in this order: index (4), then not present (1), then privilege (3), then limit (2). A good translation reports cause 0.
- R10: With `xlat_en` low, a request returns `lin_addr` equal to the offset with no fault, whatever the selector.
- R11: A write goes only to the table chosen by `wr_local`, at `wr_idx`. An entry in one table never affects the entry with the same index in the other table.
- R12: A faulting translation reports `lin_addr` as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlat_en | input | 1 | Translation enable; low means pass-through |
| req | input | 1 | Translation request strobe |
| sel | input | 16 | Segment selector |
| offset | input | 32 | Offset within segment |
| cpl | input | 2 | Current privilege level |
| wr_en | input | 1 | Descriptor write strobe |
| wr_local | input | 1 | Write target: 1 local table, 0 global table |
| wr_idx | input | $clog2(ENTRIES) | Entry written |
| wr_base | input | 32 | Segment base to write |
| wr_limit | input | 32 | Segment limit to write (inclusive) |
| wr_dpl | input | 2 | Descriptor privilege to write |
| wr_present | input | 1 | Present bit to write |
| lin_addr | output | 32 | Linear address |
| valid | output | 1 | Result valid, one cycle after request |
| fault | output | 1 | Translation faulted |
| cause | output | 3 | Fault cause code |

## Verification
The bench aims at the limit boundary. An offset equal to the limit must pass and one above it must fault; an off-by-one compare gets one of these two wrong. It covers a requested privilege that is weaker than the current one, which a design that uses only the current level would let through. It also covers an access that breaks both privilege and limit, which a wrong priority order would report with the limit cause.

Other cases:
- An index just past the table must fault, not read an entry that was truncated to the table size.
- A base plus offset that wraps past 2^32 must give the wrapped address.
- A local selector whose index is filled only in the global table must fault as not present. A design that ignores the table bit would translate it.
- With translation disabled, a bad selector must pass straight through.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    localparam int SEL_W   = 16;
    localparam int ADDR_W  = 32;
    localparam int PL_W    = 2;
    localparam int SIDX_W  = SEL_W - PL_W - 1;
    localparam int CAUSE_W = 3;

    typedef struct packed {
        logic              present;
        logic [PL_W-1:0]   dpl;
        logic [ADDR_W-1:0] limit;
        logic [ADDR_W-1:0] base;
    } seg_desc_t;

    typedef struct packed {
        logic [SIDX_W-1:0] index;
        logic              local_tbl;
        logic [PL_W-1:0]   rpl;
    } seg_sel_t;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_ABSENT  = 3'd1,
        CAUSE_LIMIT   = 3'd2,
        CAUSE_PRIV    = 3'd3,
        CAUSE_INDEX   = 3'd4
    } fault_cause_e;

    typedef struct packed {
        logic              fault;
        fault_cause_e      cause;
        logic [ADDR_W-1:0] lin;
    } xlat_res_t;

    function automatic logic [PL_W-1:0] weaker_pl(input logic [PL_W-1:0] a,
                                                  input logic [PL_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
    import seg_xlat_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  seg_desc_t        wr_desc,
    input  logic [IDX_W-1:0] rd_idx,
    output seg_desc_t        rd_desc
);

    seg_desc_t mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    mem[i] <= wr_desc;
                end
            end
        end
    end

    always_comb begin
        rd_desc = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_desc = mem[i];
            end
        end
    end

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlat_pkg::*;
(
    input  logic              xlat_en,
    input  logic              idx_ok,
    input  seg_desc_t         desc,
    input  logic [ADDR_W-1:0] offset,
    input  logic [PL_W-1:0]   cpl,
    input  logic [PL_W-1:0]   rpl,
    output xlat_res_t         res
);

    logic [PL_W-1:0] eff_pl;

    always_comb begin
        eff_pl    = weaker_pl(cpl, rpl);
        res.fault = 1'b0;
        res.cause = CAUSE_NONE;
        res.lin   = '0;
        if (!xlat_en) begin
            res.lin = offset;
        end else if (!idx_ok) begin
            res.fault = 1'b1;
            res.cause = CAUSE_INDEX;
        end else if (!desc.present) begin
            res.fault = 1'b1;
            res.cause = CAUSE_ABSENT;
        end else if (eff_pl > desc.dpl) begin
            res.fault = 1'b1;
            res.cause = CAUSE_PRIV;
        end else if (offset > desc.limit) begin
            res.fault = 1'b1;
            res.cause = CAUSE_LIMIT;
        end else begin
            res.lin = desc.base + offset;
        end
    end

endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
    import seg_xlat_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xlat_en,
    input  logic              req,
    input  logic [SEL_W-1:0]  sel,
    input  logic [ADDR_W-1:0] offset,
    input  logic [PL_W-1:0]   cpl,
    input  logic              wr_en,
    input  logic              wr_local,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [ADDR_W-1:0] wr_limit,
    input  logic [PL_W-1:0]   wr_dpl,
    input  logic              wr_present,
    output logic [ADDR_W-1:0] lin_addr,
    output logic              valid,
    output logic              fault,
    output logic [CAUSE_W-1:0] cause
);

    localparam logic [SIDX_W-1:0] ENTRIES_V = SIDX_W'(ENTRIES);

    seg_sel_t  sel_f;
    seg_desc_t wr_desc;
    seg_desc_t tbl_rd [2];
    seg_desc_t desc_sel;
    logic      idx_ok;
    xlat_res_t res;

    assign sel_f   = seg_sel_t'(sel);
    assign idx_ok  = sel_f.index < ENTRIES_V;
    assign wr_desc = '{present: wr_present, dpl: wr_dpl, limit: wr_limit, base: wr_base};

    for (genvar t = 0; t < 2; t++) begin : g_tbl
        seg_desc_table #(.ENTRIES(ENTRIES)) u_tbl (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en && (wr_local == 1'(t))),
            .wr_idx  (wr_idx),
            .wr_desc (wr_desc),
            .rd_idx  (sel_f.index[IDX_W-1:0]),
            .rd_desc (tbl_rd[t])
        );
    end

    assign desc_sel = sel_f.local_tbl ? tbl_rd[1] : tbl_rd[0];

    seg_check u_chk_logic (
        .xlat_en (xlat_en),
        .idx_ok  (idx_ok),
        .desc    (desc_sel),
        .offset  (offset),
        .cpl     (cpl),
        .rpl     (sel_f.rpl),
        .res     (res)
    );

    always_ff @(posedge clk) begin
        if (rst || !req) begin
            valid    <= 1'b0;
            fault    <= 1'b0;
            cause    <= '0;
            lin_addr <= '0;
        end else begin
            valid    <= 1'b1;
            fault    <= res.fault;
            cause    <= res.cause;
            lin_addr <= res.lin;
        end
    end

endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk
    import seg_xlat_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              xlat_en,
    input logic              req,
    input logic [SEL_W-1:0]  sel,
    input logic [ADDR_W-1:0] offset,
    input logic [ADDR_W-1:0] lin_addr,
    input logic              valid,
    input logic              fault,
    input logic [CAUSE_W-1:0] cause
);

    localparam logic [SIDX_W-1:0] LIM = SIDX_W'(ENTRIES);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!valid && !fault && cause == '0 && lin_addr == '0)); // R1

    AST_REQ_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
        req |=> valid); // R2

    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req |=> (!valid && !fault)); // R2

    AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst)
        (req && xlat_en && sel[SEL_W-1:3] >= LIM) |=> (fault && cause == 3'd4)); // R8

    AST_CAUSE_CONSISTENT: assert property (@(posedge clk) disable iff (rst)
        valid |-> (fault == (cause != 3'd0))); // R9

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (req && !xlat_en) |=> (!fault && lin_addr == $past(offset))); // R10

    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
        fault |-> (valid && lin_addr == '0)); // R12

endmodule

bind seg_xlat seg_xlat_chk #(.ENTRIES(ENTRIES)) u_seg_xlat_chk (
    .clk      (clk),
    .rst      (rst),
    .xlat_en  (xlat_en),
    .req      (req),
    .sel      (sel),
    .offset   (offset),
    .lin_addr (lin_addr),
    .valid    (valid),
    .fault    (fault),
    .cause    (cause)
);

// File: tb/seg_xlat_test.sv
`timescale 1ns/1ps
module seg_xlat_test;

    localparam int ENTRIES = 8;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int NV      = 14;

    typedef struct packed {
        logic [15:0] sel;
        logic [31:0] off;
        logic [1:0]  cpl;
        logic [2:0]  cause;
        logic [31:0] lin;
    } vec_t;

    // Table contents: G0 base 1000_0000 lim FFF dpl0; G1 base 2000 lim max dpl3;
    // G2 absent; G3 base FFFF_F000 lim max dpl3; L0 base 0050_0000 lim FF dpl3.
    localparam vec_t VECS [NV] = '{
        '{16'h000B, 32'h0000_0010, 2'd3, 3'd0, 32'h0000_2010}, // R4 R3
        '{16'h0000, 32'h0000_0FFF, 2'd0, 3'd0, 32'h1000_0FFF}, // R5 limit equal
        '{16'h0000, 32'h0000_1000, 2'd0, 3'd2, 32'h0},         // R5 above limit
        '{16'h0000, 32'h0000_0000, 2'd3, 3'd3, 32'h0},         // R7 cpl
        '{16'h0002, 32'h0000_0000, 2'd0, 3'd3, 32'h0},         // R7 rpl
        '{16'h0013, 32'h0000_0000, 2'd3, 3'd1, 32'h0},         // R6
        '{16'h0007, 32'h0000_00FF, 2'd3, 3'd0, 32'h0050_00FF}, // R11 local
        '{16'h0007, 32'h0000_0100, 2'd3, 3'd2, 32'h0},         // R5 local
        '{16'h0040, 32'h0000_0000, 2'd0, 3'd4, 32'h0},         // R8
        '{16'h0044, 32'h0000_0000, 2'd0, 3'd4, 32'h0},         // R8 local
        '{16'h0000, 32'h0000_2000, 2'd3, 3'd3, 32'h0},         // R9 priv over limit
        '{16'h001B, 32'h0000_2000, 2'd0, 3'd0, 32'h0000_1000}, // R4 wrap
        '{16'h000C, 32'h0000_0000, 2'd0, 3'd1, 32'h0},         // R11 local 1 empty
        '{16'h0013, 32'hFFFF_FFFF, 2'd3, 3'd1, 32'h0}          // R9 absent first
    };

    function automatic string vtag(input int i);
        case (i)
            0:  return "R4";
            1:  return "R5";
            2:  return "R5";
            3:  return "R7";
            4:  return "R7";
            5:  return "R6";
            6:  return "R11";
            7:  return "R5";
            8:  return "R8";
            9:  return "R8";
            10: return "R9";
            11: return "R4";
            12: return "R11";
            default: return "R9";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst;
    logic        xlat_en;
    logic        req;
    logic [15:0] sel;
    logic [31:0] offset;
    logic [1:0]  cpl;
    logic        wr_en;
    logic        wr_local;
    logic [IDX_W-1:0] wr_idx;
    logic [31:0] wr_base;
    logic [31:0] wr_limit;
    logic [1:0]  wr_dpl;
    logic        wr_present;
    logic [31:0] lin_addr;
    logic        valid;
    logic        fault;
    logic [2:0]  cause;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    seg_xlat #(.ENTRIES(ENTRIES)) uut (
        .clk(clk), .rst(rst), .xlat_en(xlat_en), .req(req), .sel(sel),
        .offset(offset), .cpl(cpl), .wr_en(wr_en), .wr_local(wr_local),
        .wr_idx(wr_idx), .wr_base(wr_base), .wr_limit(wr_limit),
        .wr_dpl(wr_dpl), .wr_present(wr_present), .lin_addr(lin_addr),
        .valid(valid), .fault(fault), .cause(cause)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_desc(input logic loc, input int idx, input logic [31:0] b,
                              input logic [31:0] l, input logic [1:0] d, input logic p);
        @(negedge clk);
        wr_en = 1'b1; wr_local = loc; wr_idx = IDX_W'(idx);
        wr_base = b; wr_limit = l; wr_dpl = d; wr_present = p;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic issue(input logic [15:0] s, input logic [31:0] o, input logic [1:0] c);
        @(negedge clk);
        req = 1'b1; sel = s; offset = o; cpl = c;
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; xlat_en = 1'b1; req = 1'b0; sel = '0; offset = '0; cpl = '0;
        wr_en = 1'b0; wr_local = 1'b0; wr_idx = '0; wr_base = '0; wr_limit = '0;
        wr_dpl = '0; wr_present = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        check("R1 valid", 32'(valid), 32'd0);
        check("R1 fault", 32'(fault), 32'd0);
        check("R1 lin", lin_addr, 32'd0);
        rst = 1'b0;

        // R1: tables empty after reset, so global 0 is absent
        issue(16'h0000, 32'h0, 2'd0);
        check("R1 cause after reset", 32'(cause), 32'd1);

        write_desc(1'b0, 0, 32'h1000_0000, 32'h0000_0FFF, 2'd0, 1'b1);
        write_desc(1'b0, 1, 32'h0000_2000, 32'hFFFF_FFFF, 2'd3, 1'b1);
        write_desc(1'b0, 2, 32'h0300_0000, 32'hFFFF_FFFF, 2'd3, 1'b0);
        write_desc(1'b0, 3, 32'hFFFF_F000, 32'hFFFF_FFFF, 2'd3, 1'b1);
        write_desc(1'b1, 0, 32'h0050_0000, 32'h0000_00FF, 2'd3, 1'b1);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].sel, VECS[i].off, VECS[i].cpl);
            check({vtag(i), " valid"}, 32'(valid), 32'd1);
            check({vtag(i), " fault"}, 32'(fault), 32'(VECS[i].cause != 3'd0));
            check({vtag(i), " cause"}, 32'(cause), 32'(VECS[i].cause));
            check({vtag(i), " lin"}, lin_addr, VECS[i].lin);
        end

        // R2: one cycle of valid only
        @(negedge clk);
        check("R2 valid drops", 32'(valid), 32'd0);
        check("R2 lin idle", lin_addr, 32'd0);

        // R10: pass-through with a bad selector
        xlat_en = 1'b0;
        issue(16'hFFFF, 32'hDEAD_BEEF, 2'd3);
        check("R10 fault", 32'(fault), 32'd0);
        check("R10 lin", lin_addr, 32'hDEAD_BEEF);
        xlat_en = 1'b1;

        // R11: write local 1, global 1 unchanged
        write_desc(1'b1, 1, 32'h0700_0000, 32'h0000_000F, 2'd0, 1'b1);
        issue(16'h000B, 32'h0000_0010, 2'd3);
        check("R11 global kept", lin_addr, 32'h0000_2010);
        issue(16'h000C, 32'h0000_0004, 2'd0);
        check("R11 local new", lin_addr, 32'h0700_0004);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule